// File: doc/BRIEF.md
# Ping-Pong Receive Ring Writer

This engine stores incoming Ethernet frames in memory. Memory is organised as a ring of equal-sized slots that follow each other from a base address. Two register sets each describe a whole ring. A set has a base address, a count of slots still free and an arm state. Only one set is active at a time. The engine writes each accepted frame into the next free slot of the active set. The payload goes first, behind a 16-byte header area. The engine then fills in the header with the stored length, the error nibble, the runt count and the collision count. It then lowers the free count by one and raises an interrupt.

When a set runs out of slots it disarms itself and the other set becomes active. Software can then reload the empty set while the other one takes traffic. Software can also stop a set and read back its free count to find the ring head. It re-arms the set, or acknowledges the completion. A channel-level control word resets, enables or disables the whole engine. A frame that arrives while the active set cannot take it is thrown away and recorded in a sticky error flag.

Top module: `rxr_dma_ring`

## Requirements
- R1: An accepted frame's payload byte i is written to base + s*2048 + 16 + i. Here s = 8 − (free count of the active set at frame start), so the first slot filled after loading count 8 is slot 0.
- R2: After the last payload byte the engine spends four cycles on the header, with `in_ready` low. It writes four bytes: offset 0 gets the stored length bits 7:0. Offset 2 gets {frame error nibble, length bits 11:8}. Offset 4 gets the runt count and offset 6 gets the collision count.
- R3: No more than 2032 payload bytes are stored per slot. Further bytes are not written, and the length field records 2032. No write ever leaves the slot.
- R4: Each stored frame lowers the set's free count (register word 1 or 5) by one. It also sets the done flag (status bit 8) and `irq`.
- R5: Writing 0x0100 to either set's command word (word 2 or 6) clears the done flag. `irq` then drops if no error is pending.
- R6: When a stored frame brings the free count to zero, that set disarms (command word readback bit 15 = 0). The active-set index (status bit 4) toggles, and the next frame goes to the other set.
- R7: A frame that arrives while the channel is enabled but the active set is unarmed or has no free slot causes no memory write. It sets the sticky error flag (status bit 13) and `irq`.
- R8: Command 0x1100 disarms a set. Command 0x9800 arms it again, and filling resumes at the next free slot.
- R9: Control word 0x8800 (word 8) clears the error and done flags, disarms both sets, selects set 0 and disables the channel. Control 0x0400 enables the channel (status bit 10). Control 0x1000 disables it, and frames received while disabled are dropped with no write and no error.
- R10: A free-count write larger than 8 is clamped to 8.
- R11: After reset, `irq` is 0, `in_ready` is 1, and the status, free counts and command readbacks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 4 | Word index: 0-2 set 0, 4-6 set 1, 8 channel control/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_word` |
| fr_valid | input | 1 | Frame byte valid |
| fr_data | input | 8 | Frame byte |
| fr_last | input | 1 | Marks the final byte of a frame |
| fr_err | input | 4 | Frame error nibble, sampled with the final byte |
| fr_runt | input | 8 | Runt count, sampled with the final byte |
| fr_coll | input | 8 | Collision count, sampled with the final byte |
| in_ready | output | 1 | Engine can take a byte this cycle |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 8 | Memory byte data |
| irq | output | 1 | Done or error pending |

## Verification
The tests send frames of 1, 20, 60 and 300 bytes, and one of 2040 bytes. The long frame separates the storage cap from plain counting. The short ones show the header layout and the error nibble packing. Drops are provoked three ways: a stopped set, a set with no free slots left, and a disabled channel. These tell the sticky-error path apart from the silent one. Some ring counts are small enough that the active set changes twice. This shows that slot numbering restarts from each set's own base and count.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef logic [31:0] addr_t;
  typedef enum logic [1:0] {W_IDLE, W_RECV, W_DROP, W_HDR} wstate_t;

  localparam logic [15:0] CMD_ARM  = 16'h9800;
  localparam logic [15:0] CMD_STOP = 16'h1100;
  localparam logic [15:0] CMD_ACK  = 16'h0100;
  localparam logic [15:0] CTL_RST  = 16'h8800;
  localparam logic [15:0] CTL_GO   = 16'h0400;
  localparam logic [15:0] CTL_OFF  = 16'h1000;

  // start address of slot idx in a ring of equal slots
  function automatic addr_t slot_addr(addr_t base, int unsigned idx, int unsigned bytes);
    return base + addr_t'(idx * bytes);
  endfunction

  // second header byte: error nibble over length high nibble
  function automatic logic [7:0] stat_byte(logic [3:0] errs, logic [11:0] len);
    return {errs, len[11:8]};
  endfunction
endpackage

// File: rtl/rxr_set.sv
module rxr_set
  import rxr_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we_base,
  input  logic          we_len,
  input  logic          we_cmd,
  input  logic [31:0]   wdata,
  input  logic          fill,
  output addr_t         base,
  output logic [CW-1:0] left,
  output logic          armed
);
  logic [CW-1:0] len_wr;
  assign len_wr = (int'(wdata[15:0]) > SLOTS) ? CW'(SLOTS) : wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      left  <= '0;
      armed <= 1'b0;
    end else begin
      if (we_base) base <= wdata;
      if (we_len) left <= len_wr;
      else if (fill && left != '0) left <= left - CW'(1);
      if (clr) armed <= 1'b0;
      else if (we_cmd && wdata[15:0] == CMD_ARM) armed <= 1'b1;
      else if (we_cmd && wdata[15:0] == CMD_STOP) armed <= 1'b0;
      else if (fill && left == CW'(1)) armed <= 1'b0;
    end
  end

  AST_LEFT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(left) <= SLOTS); // R10
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fill && !we_len && left != '0 |=> left == $past(left) - CW'(1)); // R4
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 2048,
  parameter int HDR_BYTES  = 16,
  parameter int CW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          fr_valid,
  input  logic [7:0]    fr_data,
  input  logic          fr_last,
  input  logic [3:0]    fr_err,
  input  logic [7:0]    fr_runt,
  input  logic [7:0]    fr_coll,
  output logic          in_ready,
  input  logic          accept,
  input  addr_t         base_cur,
  input  logic [CW-1:0] left_cur,
  output logic          mem_we,
  output addr_t         mem_addr,
  output logic [7:0]    mem_data,
  output logic          done_evt,
  output logic          drop_evt
);
  localparam int LW = 12;
  localparam logic [LW-1:0] CAP = LW'(SLOT_BYTES - HDR_BYTES);

  wstate_t       st;
  addr_t         slot_base, new_base, cur_base;
  logic [LW-1:0] cnt, pay_idx, len_after;
  logic [1:0]    hcnt;
  logic [3:0]    err_q;
  logic [7:0]    runt_q, coll_q;
  logic          take, pay_we;

  assign in_ready  = (st != W_HDR);
  assign take      = fr_valid && in_ready;
  assign new_base  = slot_addr(base_cur, int'(SLOTS) - int'(left_cur), SLOT_BYTES);
  assign cur_base  = (st == W_IDLE) ? new_base : slot_base;
  assign pay_idx   = (st == W_IDLE) ? '0 : cnt;
  assign pay_we    = take && (((st == W_IDLE) && accept) || ((st == W_RECV) && cnt < CAP));
  assign len_after = pay_idx + (pay_we ? LW'(1) : LW'(0));
  assign done_evt  = (st == W_HDR) && (hcnt == 2'd3);
  assign drop_evt  = (st == W_IDLE) && take && !accept;

  always_comb begin
    mem_we   = pay_we || (st == W_HDR);
    mem_addr = cur_base + addr_t'(HDR_BYTES) + addr_t'(pay_idx);
    mem_data = fr_data;
    if (st == W_HDR) begin
      mem_addr = slot_base + addr_t'({hcnt, 1'b0});
      case (hcnt)
        2'd0:    mem_data = cnt[7:0];
        2'd1:    mem_data = stat_byte(err_q, cnt);
        2'd2:    mem_data = runt_q;
        default: mem_data = coll_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      slot_base <= '0;
      cnt       <= '0;
      hcnt      <= '0;
      err_q     <= '0;
      runt_q    <= '0;
      coll_q    <= '0;
    end else if (abort) begin
      st   <= W_IDLE;
      hcnt <= '0;
    end else begin
      if (take && fr_last) begin
        err_q  <= fr_err;
        runt_q <= fr_runt;
        coll_q <= fr_coll;
      end
      case (st)
        W_IDLE: if (take) begin
          if (accept) begin
            slot_base <= new_base;
            cnt       <= len_after;
            st        <= fr_last ? W_HDR : W_RECV;
          end else if (!fr_last) begin
            st <= W_DROP;
          end
        end
        W_RECV: if (take) begin
          cnt <= len_after;
          if (fr_last) st <= W_HDR;
        end
        W_DROP: if (take && fr_last) st <= W_IDLE;
        default: begin
          hcnt <= hcnt + 2'd1;
          if (hcnt == 2'd3) st <= W_IDLE;
        end
      endcase
    end
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && st != W_IDLE |-> (mem_addr - slot_base) < addr_t'(SLOT_BYTES)); // R3
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    st == W_DROP |-> !mem_we); // R7
endmodule

// File: rtl/rxr_dma_ring.sv
module rxr_dma_ring
  import rxr_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int SLOT_BYTES = 2048,
  parameter int HDR_BYTES  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_word,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        fr_valid,
  input  logic [7:0]  fr_data,
  input  logic        fr_last,
  input  logic [3:0]  fr_err,
  input  logic [7:0]  fr_runt,
  input  logic [7:0]  fr_coll,
  output logic        in_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_data,
  output logic        irq
);
  localparam int CW = $clog2(SLOTS + 1);

  addr_t         base_a  [2];
  logic [CW-1:0] left_a  [2];
  logic          armed_a [2];
  logic          cur, en, err, done;
  logic          ctl_we, ctl_rst, ack, accept, done_evt, drop_evt;
  logic [CW-1:0] left_cur;

  assign ctl_we   = reg_we && reg_word[3];
  assign ctl_rst  = ctl_we && reg_wdata[15:0] == CTL_RST;
  assign ack      = reg_we && !reg_word[3] && reg_word[1:0] == 2'd2 && reg_wdata[15:0] == CMD_ACK;
  assign left_cur = left_a[cur];
  assign accept   = en && armed_a[cur] && left_cur != '0;
  assign irq      = err || done;

  for (genvar i = 0; i < 2; i++) begin : g_set
    logic sel;
    assign sel = reg_we && !reg_word[3] && reg_word[2] == 1'(i);
    rxr_set #(.SLOTS(SLOTS), .CW(CW)) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctl_rst),
      .we_base (sel && reg_word[1:0] == 2'd0),
      .we_len  (sel && reg_word[1:0] == 2'd1),
      .we_cmd  (sel && reg_word[1:0] == 2'd2),
      .wdata   (reg_wdata),
      .fill    (done_evt && cur == 1'(i)),
      .base    (base_a[i]),
      .left    (left_a[i]),
      .armed   (armed_a[i])
    );
  end

  rxr_writer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES), .HDR_BYTES(HDR_BYTES), .CW(CW)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (ctl_rst),
    .fr_valid (fr_valid),
    .fr_data  (fr_data),
    .fr_last  (fr_last),
    .fr_err   (fr_err),
    .fr_runt  (fr_runt),
    .fr_coll  (fr_coll),
    .in_ready (in_ready),
    .accept   (accept),
    .base_cur (base_a[cur]),
    .left_cur (left_cur),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .done_evt (done_evt),
    .drop_evt (drop_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= 1'b0;
      en   <= 1'b0;
      err  <= 1'b0;
      done <= 1'b0;
    end else if (ctl_rst) begin
      cur  <= 1'b0;
      en   <= 1'b0;
      err  <= 1'b0;
      done <= 1'b0;
    end else begin
      if (ctl_we && reg_wdata[15:0] == CTL_GO) en <= 1'b1;
      if (ctl_we && reg_wdata[15:0] == CTL_OFF) en <= 1'b0;
      if (drop_evt && en) err <= 1'b1;
      if (done_evt) done <= 1'b1;
      else if (ack) done <= 1'b0;
      if (done_evt && left_cur == CW'(1)) cur <= ~cur;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_word[3]) begin
      reg_rdata[13] = err;
      reg_rdata[10] = en;
      reg_rdata[8]  = done;
      reg_rdata[4]  = cur;
    end else begin
      case (reg_word[1:0])
        2'd0:    reg_rdata = base_a[reg_word[2]];
        2'd1:    reg_rdata = 32'(left_a[reg_word[2]]);
        2'd2:    reg_rdata[15] = armed_a[reg_word[2]];
        default: reg_rdata = '0;
      endcase
    end
  end

  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !ctl_rst |=> irq); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !done_evt && !err && !drop_evt |=> !irq); // R5
  AST_SWAP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && left_cur == CW'(1) && !ctl_rst |=> cur != $past(cur)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !ctl_rst |=> err); // R7
endmodule

// File: tb/sim_rxr_dma_ring.sv
module sim_rxr_dma_ring;
  localparam int PERIOD = 10;
  localparam int SLOTS  = 8;
  localparam int SB     = 2048;
  localparam int HB     = 16;
  localparam int CAP    = SB - HB;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_word = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        fr_valid = 1'b0, fr_last = 1'b0;
  logic [7:0]  fr_data = '0, fr_runt = '0, fr_coll = '0;
  logic [3:0]  fr_err = '0;
  logic        in_ready, mem_we, irq;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data;

  rxr_dma_ring #(.SLOTS(SLOTS), .SLOT_BYTES(SB), .HDR_BYTES(HB)) u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] qa[$];
  logic [7:0]  qd[$];
  logic [31:0] m_base[2];
  int          m_left[2];
  bit          m_arm[2];
  bit          m_cur, m_en, m_err, m_done;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 13 + seed) & 255);
  endfunction

  // per-clock comparison of the memory port with the model's queue
  always @(negedge clk) begin
    #(PERIOD/4);
    cyc++;
    if (rst_n && mem_we) begin
      if (qa.size() == 0) chk("R1 R7 R9 unexpected write", mem_addr, 32'hFFFF_FFFF);
      else begin
        chk("R1 R2 write addr", mem_addr, qa.pop_front());
        chk("R1 R2 write data", 32'(mem_data), 32'(qd.pop_front()));
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic reg_wr(int w, logic [31:0] d);
    int s;
    @(negedge clk);
    reg_we = 1'b1; reg_word = 4'(w); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (w == 8) begin
      if (d[15:0] == 16'h8800) begin
        m_en = 0; m_err = 0; m_done = 0; m_cur = 0; m_arm[0] = 0; m_arm[1] = 0;
      end else if (d[15:0] == 16'h0400) m_en = 1;
      else if (d[15:0] == 16'h1000) m_en = 0;
    end else begin
      s = w / 4;
      case (w % 4)
        0: m_base[s] = d;
        1: m_left[s] = (int'(d[15:0]) > SLOTS) ? SLOTS : int'(d[15:0]);
        2: begin
          if (d[15:0] == 16'h9800) m_arm[s] = 1;
          else if (d[15:0] == 16'h1100) m_arm[s] = 0;
          else if (d[15:0] == 16'h0100) m_done = 0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic rd_chk(string tag, int w, logic [31:0] exp);
    @(negedge clk);
    reg_word = 4'(w);
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic state_chk(string tag);
    logic [31:0] st;
    st = (32'(m_err) << 13) | (32'(m_en) << 10) | (32'(m_done) << 8) | (32'(m_cur) << 4);
    rd_chk({tag, " status"}, 8, st);
    rd_chk({tag, " free0"}, 1, 32'(m_left[0]));
    rd_chk({tag, " free1"}, 5, 32'(m_left[1]));
    rd_chk({tag, " arm0"}, 2, m_arm[0] ? 32'h8000 : 32'h0);
    rd_chk({tag, " arm1"}, 6, m_arm[1] ? 32'h8000 : 32'h0);
    chk({tag, " irq"}, 32'(irq), 32'(m_err | m_done));
  endtask

  task automatic send(int n, int seed, logic [3:0] e, logic [7:0] runt, logic [7:0] coll);
    logic [31:0] b;
    int st;
    bit stored = 0;
    if (m_en) begin
      if (!m_arm[m_cur] || m_left[m_cur] == 0) m_err = 1;
      else begin
        stored = 1;
        b = m_base[m_cur] + 32'((SLOTS - m_left[m_cur]) * SB);
        st = (n < CAP) ? n : CAP;
        for (int i = 0; i < st; i++) begin
          qa.push_back(b + 32'(HB + i)); qd.push_back(pat(i, seed));
        end
        qa.push_back(b);      qd.push_back(8'(st));
        qa.push_back(b + 2);  qd.push_back({e, 4'(st >> 8)});
        qa.push_back(b + 4);  qd.push_back(runt);
        qa.push_back(b + 6);  qd.push_back(coll);
        m_left[m_cur]--;
        m_done = 1;
        if (m_left[m_cur] == 0) begin m_arm[m_cur] = 0; m_cur = ~m_cur; end
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fr_valid = 1'b1; fr_data = pat(i, seed); fr_last = (i == n - 1);
      fr_err = e; fr_runt = runt; fr_coll = coll;
    end
    @(negedge clk);
    fr_valid = 1'b0; fr_last = 1'b0;
    #1 if (stored) chk("R2 header stall", 32'(in_ready), 32'h0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    m_base[0] = 0; m_base[1] = 0; m_left[0] = 0; m_left[1] = 0;
    m_arm[0] = 0; m_arm[1] = 0; m_cur = 0; m_en = 0; m_err = 0; m_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    #1 chk("R11 irq", 32'(irq), 32'h0);
    chk("R11 in_ready", 32'(in_ready), 32'h1);
    state_chk("R11");

    reg_wr(8, 32'h8800);
    reg_wr(0, 32'h1000_0000); reg_wr(1, 8);
    reg_wr(4, 32'h2000_4000); reg_wr(5, 3);
    reg_wr(2, 32'h9800); reg_wr(6, 32'h9800);
    reg_wr(8, 32'h0400);

    send(60, 1, 4'h0, 8'd3, 8'd1);          // R1 slot 0
    state_chk("R4 first frame");
    reg_wr(2, 32'h0100);
    state_chk("R5 ack set0");
    send(300, 5, 4'hA, 8'd0, 8'd2);         // R2 error nibble, length over 255
    reg_wr(6, 32'h0100);
    state_chk("R5 ack via set1");
    send(1, 9, 4'h1, 8'd7, 8'd0);           // R1 single byte frame, slot 2

    reg_wr(5, 15);
    rd_chk("R10 clamp", 5, 32'd8);
    reg_wr(5, 3);

    reg_wr(2, 32'h1100);
    send(20, 3, 4'h0, 8'd0, 8'd0);          // R7 R8 dropped on stopped set
    state_chk("R7 R8 stopped");
    reg_wr(2, 32'h9800);
    send(20, 4, 4'h0, 8'd0, 8'd0);          // R8 resumes at slot 3
    state_chk("R8 rearmed");

    reg_wr(8, 32'h8800);
    state_chk("R9 channel reset");
    reg_wr(1, 2); reg_wr(2, 32'h9800); reg_wr(6, 32'h9800);
    reg_wr(8, 32'h0400);
    send(40, 11, 4'h0, 8'd0, 8'd5);         // slot 6
    send(2040, 2, 4'h3, 8'd1, 8'd1);        // R3 capped, slot 7, set0 empties
    state_chk("R6 swap to set1");
    send(33, 6, 4'h0, 8'd0, 8'd0);          // R6 lands in set1 slot 5

    reg_wr(8, 32'h1000);
    send(10, 8, 4'h0, 8'd0, 8'd0);          // R9 silent drop
    state_chk("R9 disabled");
    reg_wr(8, 32'h0400);
    send(10, 8, 4'h0, 8'd0, 8'd0);          // set1 slot 6
    send(5, 12, 4'h0, 8'd0, 8'd0);          // set1 slot 7, swap back to set0
    state_chk("R6 swap back");
    send(5, 13, 4'h0, 8'd0, 8'd0);          // R7 set0 empty and unarmed
    state_chk("R7 empty ring");

    chk("R1 R2 all writes seen", 32'(qa.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule